// File: doc/BRIEF.md
# Clock-Generating Synchronous Serial Receiver

This block receives serial data as the clock master. While enabled it drives its own shift clock, derived from the system clock through a divider. It samples one NRZ data line and assembles words most-significant bit first. Each finished word moves into a single receive buffer. A ready flag marks the buffer as holding valid data, and a one-cycle interrupt pulse can announce it.

A host empties the buffer by pulsing a read strobe. If a word finishes while the buffer is still unread, the block parks the shift clock at its idle level and keeps that word in the shift register until the read arrives, so no data is ever overwritten. Raising the active-low enable ends reception at once. Any bits gathered so far are latched into the buffer, which allows words shorter than the full width. A finished word that was parked also replaces the buffer at that point.

A mode input picks which shift-clock edge the remote sender changes data on. The block samples on the other edge. The clock rests at a level chosen so that the first edge after enabling is always a data-change edge.

Top module: `sync_rx_master`

## Requirements
- R1: After reset the ready flag reads 1 (buffer empty), the interrupt is 0 and the buffer holds all zeros. With the mode input at 0 during reset, the shift clock reads 1.
- R2: While disabled, the shift clock rests at the inverse of the mode input. Mode 1 means data changes on the rising edge and the clock idles low. Mode 0 means data changes on the falling edge and the clock idles high. The first edge after enabling is therefore a data-change edge.
- R3: The data input is sampled on the edge opposite the data-change edge. The first bit sampled ends up in buffer bit DATA_W-1 and the last in bit 0.
- R4: Each full word takes exactly DATA_W data-change edges and DATA_W sampling edges. At the last sampling edge the word enters the buffer and the ready flag goes to 0 (0 = valid).
- R5: Every transfer into the buffer produces a one-cycle interrupt pulse when the interrupt enable is 1, and no pulse when it is 0.
- R6: A one-cycle read strobe sets the ready flag to 1 unless a transfer occurs in the same cycle.
- R7: After a transfer the block keeps clocking the next word without pausing.
- R8: If a word completes while the ready flag is 0, the shift clock stops at its idle level and the buffer keeps its old word. After the next read strobe the held word enters the buffer, the ready flag stays 0, and clocking resumes.
- R9: Disabling after k sampled bits (0 < k < DATA_W) copies those bits into buffer bits k-1..0, clears the upper bits, and sets the ready flag to 0.
- R10: Disabling while a completed word is held copies that word into the buffer, even if the buffer was unread.
- R11: Disabling before any bit of the current word has been sampled leaves the buffer and ready flag untouched and returns the shift clock to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low receive enable |
| edge_sel | input | 1 | 1: data changes on rising shift-clock edge; 0: on falling edge |
| sdi | input | 1 | Serial data in |
| rd_strobe | input | 1 | One-cycle buffer read pulse |
| irq_en | input | 1 | Interrupt enable |
| sck | output | 1 | Generated shift clock |
| rx_buf | output | DATA_W | Receive buffer |
| rdy_n | output | 1 | Buffer state, 0 = holds unread data |
| irq | output | 1 | One-cycle transfer interrupt |

## Verification
The bench builds the block with DATA_W = 8 and HALF_DIV = 2. Each shift-clock half period is then two system cycles. A full word takes only 32 cycles, so long stalls, several chained words and mid-word disables all fit in a short run. The short half period also leaves a behavioural sender model, driven off the observed clock edges, several cycles between its data change and the block's sample. With this setting the bench can count edges exactly and place disables just before or just after a sampling edge.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_SHIFT = 2'd1,
      RX_HOLD  = 2'd2
   } rx_state_e;
endpackage

// File: rtl/sync_rx_tick_gen.sv
module sync_rx_tick_gen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (!run || cnt_q == LAST) cnt_q <= '0;
            else                           cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift,
   input  logic              sdi,
   output logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] next_word,
   output logic              last,
   output logic              empty
);
   localparam int BW = $clog2(DATA_W);
   localparam logic [BW-1:0] TOP = BW'(DATA_W - 1);

   logic [BW-1:0] bit_q;

   assign next_word = {data[DATA_W-2:0], sdi};
   assign last      = (bit_q == TOP);
   assign empty     = (bit_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         bit_q <= '0;
      end else if (clear) begin
         data  <= '0;
         bit_q <= '0;
      end else if (shift) begin
         data  <= next_word;
         bit_q <= last ? '0 : bit_q + 1'b1;
      end
   end
endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rd,
   input  logic              irq_en,
   output logic [DATA_W-1:0] rx_buf,
   output logic              rdy_n,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf <= '0;
         rdy_n  <= 1'b1;
         irq    <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (load) begin
            rx_buf <= load_data;
            rdy_n  <= 1'b0;
            irq    <= irq_en;
         end else if (rd) begin
            rdy_n <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
   parameter int DATA_W   = 8,
   parameter int HALF_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              edge_sel,
   input  logic              sdi,
   input  logic              rd_strobe,
   input  logic              irq_en,
   output logic              sck,
   output logic [DATA_W-1:0] rx_buf,
   output logic              rdy_n,
   output logic              irq
);
   import sync_rx_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_rx_master: DATA_W must be at least 2");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("sync_rx_master: HALF_DIV must be at least 1");
      end
   endgenerate

   rx_state_e         st_q, st_d;
   logic              tick, ph_q;
   logic              sh_clear, sh_shift, sh_last, sh_empty;
   logic [DATA_W-1:0] sh_data, sh_next;
   logic              load;
   logic [DATA_W-1:0] load_data;
   logic              buf_free, sample_tick;
   logic              in_hold;

   assign buf_free    = rdy_n | rd_strobe;
   assign sample_tick = tick & ph_q;
   assign in_hold     = (st_q == RX_HOLD);

   sync_rx_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == RX_SHIFT),
      .tick  (tick)
   );

   sync_rx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (sh_clear),
      .shift     (sh_shift),
      .sdi       (sdi),
      .data      (sh_data),
      .next_word (sh_next),
      .last      (sh_last),
      .empty     (sh_empty)
   );

   sync_rx_buffer #(.DATA_W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (load_data),
      .rd        (rd_strobe),
      .irq_en    (irq_en),
      .rx_buf    (rx_buf),
      .rdy_n     (rdy_n),
      .irq       (irq)
   );

   always_comb begin
      st_d      = st_q;
      load      = 1'b0;
      load_data = sh_data;
      sh_clear  = 1'b0;
      sh_shift  = 1'b0;
      unique case (st_q)
         RX_IDLE: begin
            if (!en_n) begin
               st_d     = RX_SHIFT;
               sh_clear = 1'b1;
            end
         end
         RX_SHIFT: begin
            if (en_n) begin
               st_d = RX_IDLE;
               load = !sh_empty;
            end else if (sample_tick) begin
               sh_shift = 1'b1;
               if (sh_last) begin
                  if (buf_free) begin
                     load      = 1'b1;
                     load_data = sh_next;
                     sh_clear  = 1'b1;
                  end else begin
                     st_d = RX_HOLD;
                  end
               end
            end
         end
         RX_HOLD: begin
            if (en_n) begin
               st_d = RX_IDLE;
               load = 1'b1;
            end else if (buf_free) begin
               st_d     = RX_SHIFT;
               load     = 1'b1;
               sh_clear = 1'b1;
            end
         end
         default: st_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RX_IDLE;
         sck  <= 1'b1;
         ph_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d == RX_IDLE)
            sck <= ~edge_sel;
         else if (st_q == RX_SHIFT && tick)
            sck <= ~sck;
         if (st_q != RX_SHIFT)
            ph_q <= 1'b0;
         else if (tick)
            ph_q <= ~ph_q;
      end
   end
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_n,
   input logic              edge_sel,
   input logic              rd_strobe,
   input logic              sck,
   input logic [DATA_W-1:0] rx_buf,
   input logic              rdy_n,
   input logic              irq,
   input logic              hold
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !rdy_n);

   assert_keep_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !rd_strobe) |=> !rdy_n);

   assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && en_n && $past(en_n) && $stable(edge_sel)) |-> (sck == ~edge_sel));

   assert_stall_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && hold && $past(hold)) |-> $stable(sck));

   assert_buf_change_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$stable(rx_buf)) |-> !rdy_n);
endmodule

bind sync_rx_master sync_rx_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_n      (en_n),
   .edge_sel  (edge_sel),
   .rd_strobe (rd_strobe),
   .sck       (sck),
   .rx_buf    (rx_buf),
   .rdy_n     (rdy_n),
   .irq       (irq),
   .hold      (in_hold)
);

// File: tb/sync_rx_master_bench.sv
module sync_rx_master_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_n = 1'b1, edge_sel = 1'b0, sdi = 1'b0, rd_strobe = 1'b0, irq_en = 1'b1;
   logic sck, rdy_n, irq;
   logic [W-1:0] rx_buf;

   always #4 clk = ~clk;

   sync_rx_master #(.DATA_W(W), .HALF_DIV(2)) u_sync_rx_master (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .edge_sel(edge_sel), .sdi(sdi),
      .rd_strobe(rd_strobe), .irq_en(irq_en), .sck(sck), .rx_buf(rx_buf),
      .rdy_n(rdy_n), .irq(irq));

   // Sender model: changes data on the data-change edge, counts both edge kinds
   logic [31:0] tx_stream = '0;
   int tx_idx = 0, samp_cnt = 0, trans_cnt = 0, irq_cnt = 0;
   logic sck_q = 1'b1;
   always @(negedge clk) begin
      if (irq) irq_cnt <= irq_cnt + 1;
      if (en_n) begin
         tx_idx <= 0; samp_cnt <= 0; trans_cnt <= 0;
      end else if (sck !== sck_q) begin
         if (sck === edge_sel) begin
            sdi       <= (tx_idx < 32) ? tx_stream[31 - tx_idx] : 1'b0;
            tx_idx    <= tx_idx + 1;
            trans_cnt <= trans_cnt + 1;
         end else begin
            samp_cnt <= samp_cnt + 1;
         end
      end
      sck_q <= sck;
   end

   int n_chk = 0, n_fail = 0, wd = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_ready(input string req);
      int n = 0;
      while (rdy_n !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
      check(rdy_n === 1'b0, req, rdy_n, 0);
   endtask

   task automatic wait_samples(input int target, input string req);
      int n = 0;
      while (samp_cnt < target && n < 3000) begin @(negedge clk); n++; end
      check(samp_cnt == target, req, samp_cnt, target);
   endtask

   task automatic read_buf();
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
   endtask

   // {irq_en, mode, data}
   localparam logic [9:0] VEC [6] = '{
      {1'b1, 1'b0, 8'h35}, {1'b1, 1'b1, 8'h35}, {1'b1, 1'b0, 8'hA5},
      {1'b0, 1'b1, 8'h3C}, {1'b1, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'h00}};

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 150000) begin
         $display("FAIL watchdog: actual %0d expected below 150000", wd);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
         $finish;
      end
   end

   initial begin
      int ic0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(sck === 1'b1, "R1 sck", sck, 1);
      check(rdy_n === 1'b1, "R1 rdy_n", rdy_n, 1);
      check(irq === 1'b0, "R1 irq", irq, 0);
      check(rx_buf === '0, "R1 buf", rx_buf, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 6; i++) begin
         irq_en = VEC[i][9]; edge_sel = VEC[i][8];
         tx_stream = {VEC[i][7:0], 24'h0};
         repeat (3) @(negedge clk);
         check(sck === ~VEC[i][8], "R2 idle level", sck, ~VEC[i][8]);
         ic0 = irq_cnt;
         en_n = 1'b0;
         wait_ready("R4 word ready");
         @(negedge clk);
         check(rx_buf === VEC[i][7:0], "R3 data msb first", rx_buf, VEC[i][7:0]);
         check(samp_cnt == 8, "R4 sample edges", samp_cnt, 8);
         check(trans_cnt == 8, "R2 change edges first", trans_cnt, 8);
         check(irq_cnt - ic0 == int'(VEC[i][9]), "R5 irq gating", irq_cnt - ic0, VEC[i][9]);
         rd_strobe = 1'b1; en_n = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0;
         check(rdy_n === 1'b1, "R6 read clears", rdy_n, 1);
         check(rx_buf === VEC[i][7:0], "R11 no latch at zero bits", rx_buf, VEC[i][7:0]);
         check(sck === ~VEC[i][8], "R11 clock idle", sck, ~VEC[i][8]);
      end

      // R7/R8/R10: chained words, stall while unread, resume, overwrite on disable
      irq_en = 1'b1; edge_sel = 1'b0;
      tx_stream = {8'h96, 8'h4B, 8'hE1, 8'h00};
      repeat (3) @(negedge clk);
      en_n = 1'b0;
      wait_ready("R7 first word");
      check(rx_buf === 8'h96, "R7 first word", rx_buf, 8'h96);
      wait_samples(16, "R7 continues");
      repeat (40) @(negedge clk);
      check(samp_cnt == 16, "R8 clock stalled", samp_cnt, 16);
      check(rx_buf === 8'h96, "R8 no overwrite", rx_buf, 8'h96);
      check(sck === 1'b1, "R8 stall at idle", sck, 1);
      ic0 = irq_cnt;
      read_buf();
      check(rx_buf === 8'h4B, "R8 held word moves", rx_buf, 8'h4B);
      check(rdy_n === 1'b0, "R8 ready stays valid", rdy_n, 0);
      check(irq === 1'b1, "R5 irq on held move", irq, 1);
      wait_samples(24, "R8 resumed");
      repeat (10) @(negedge clk);
      check(rx_buf === 8'h4B, "R8 second stall", rx_buf, 8'h4B);
      en_n = 1'b1;
      repeat (2) @(negedge clk);
      check(rx_buf === 8'hE1, "R10 held word overwrites", rx_buf, 8'hE1);
      check(rdy_n === 1'b0, "R10 ready", rdy_n, 0);
      read_buf();

      // R9: partial word of 3 bits (1,0,1)
      edge_sel = 1'b1;
      tx_stream = {8'b1010_0000, 24'h0};
      repeat (3) @(negedge clk);
      ic0 = irq_cnt;
      en_n = 1'b0;
      wait_samples(3, "R9 three bits");
      en_n = 1'b1;
      repeat (2) @(negedge clk);
      check(rx_buf === 8'h05, "R9 partial right aligned", rx_buf, 8'h05);
      check(rdy_n === 1'b0, "R9 ready", rdy_n, 0);
      check(sck === 1'b0, "R9 clock idle", sck, 0);
      check(irq_cnt - ic0 == 1, "R9 irq", irq_cnt - ic0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule